// File: doc/BRIEF.md
# Zero-Test Accumulator Processor

This block is a small stored-program processor built around a single accumulator and a program counter. One word memory holds both code and data. The processor reaches it through a plain synchronous port: an address, write data, a write enable and read data that returns one cycle after its address. Every word is the same width as the accumulator. The top three bits of a word select the operation, and the remaining bits form an absolute address.

The processor has five operations: load a word into the accumulator, store the accumulator, clear it, increment it, and jump when it holds zero. Increment is the only arithmetic, and it wraps at the word width. Branch-on-zero is the only control transfer, so an unconditional jump is written by clearing the accumulator first. Programs may write over their own instructions, and a rewritten word acts the next time it is fetched.

The processor has no halt, input or output operation. The memory is filled while reset is held and examined after a known number of instructions, each of which takes exactly two cycles.

Top module: `acc_brz_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the accumulator is zero, the fetch address is 0 and the write enable is low.
- R2: Each instruction takes two cycles. In the fetch cycle the address is the program counter and the write enable is low. The execute cycle follows at once.
- R3: Bits [11:9] of a word are the opcode and bits [8:0] are the absolute address. The opcodes are load 000, store 001, clear 010, increment 011 and branch-if-zero 100.
- R4: Load copies the word at the given address into the accumulator. The next instruction sees the new value.
- R5: In the execute cycle of a store, the address output is the given address, the write enable is high and the write data is the accumulator. No other instruction raises the write enable.
- R6: Clear sets the accumulator to zero.
- R7: Increment adds one modulo 4096, so 0xFFF becomes 0x000.
- R8: Branch-if-zero fetches next from its address field when the accumulator is zero, and from the following address otherwise. The sequential next address wraps from 511 to 0.
- R9: A word written by a store is the one executed when that address is next fetched, including the instruction that directly follows the store.
- R10: Opcodes 101, 110 and 111 change neither the accumulator nor memory, and execution moves on to the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 9 | Word address for the current cycle |
| mem_wdata | output | 12 | Data to write, always the accumulator |
| mem_we | output | 1 | Write strobe, high only during a store's execute cycle |
| mem_rdata | input | 12 | Word read at the address of the previous cycle |

## Verification
The hardest case to reach from the ports is self-modifying code. A store must overwrite an instruction that has not yet run, sometimes the very next one, and the rewritten word must be the one fetched. A directed program loads an encoded store word and writes it over the following instruction. Random programs keep every address field inside a small code region, so stores often land on code and branches land inside it. Every fetch address, store strobe and final memory image is then compared against an instruction-level model in the bench.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 3'b000,
        OP_STORE = 3'b001,
        OP_CLR   = 3'b010,
        OP_INC   = 3'b011,
        OP_BRZ   = 3'b100,
        OP_RSV5  = 3'b101,
        OP_RSV6  = 3'b110,
        OP_RSV7  = 3'b111
    } op_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic rd_mem;
        logic wr_mem;
        logic acc_clr;
        logic acc_inc;
        logic brz;
    } ctl_t;

    function automatic ctl_t decode_op(op_e op);
        ctl_t c;
        c = '0;
        case (op)
            OP_LOAD:  c.rd_mem  = 1'b1;
            OP_STORE: c.wr_mem  = 1'b1;
            OP_CLR:   c.acc_clr = 1'b1;
            OP_INC:   c.acc_inc = 1'b1;
            OP_BRZ:   c.brz     = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_cpu_pkg::*;
(
    input  phase_e                phase,
    input  logic [OPC_W-1:0]      opc,
    output ctl_t                  ctl
);

    always_comb begin
        if (phase == PH_EXEC) begin
            ctl = decode_op(op_e'(opc));
        end else begin
            ctl = '0;
        end
    end

endmodule

// File: rtl/acc_unit.sv
module acc_unit #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_due,
    input  logic              do_clr,
    input  logic              do_inc,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] acc,
    output logic              acc_zero
);

    localparam logic [WORD_W-1:0] ACC_ONE = WORD_W'(1);
    localparam logic [WORD_W-1:0] ACC_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (load_due) begin
            acc <= rdata;
        end else if (do_clr) begin
            acc <= '0;
        end else if (do_inc) begin
            acc <= acc + ACC_ONE;
        end
    end

    assign acc_zero = (acc == '0);

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load_due |=> (acc == $past(rdata)));

    // R6
    clr_result_chk: assert property (@(posedge clk) disable iff (rst)
        do_clr |=> (acc == '0));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (do_inc && acc == ACC_MAX) |=> (acc == '0));

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_load,
    input  logic              do_brz,
    input  logic              acc_zero,
    input  logic [ADDR_W-1:0] target,
    output phase_e            phase,
    output logic [ADDR_W-1:0] pc,
    output logic              load_due
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_next;

    always_comb begin
        if (do_brz && acc_zero) begin
            pc_next = target;
        end else begin
            pc_next = pc + PC_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_FETCH;
            pc       <= '0;
            load_due <= 1'b0;
        end else if (phase == PH_FETCH) begin
            phase    <= PH_EXEC;
            load_due <= 1'b0;
        end else begin
            phase    <= PH_FETCH;
            pc       <= pc_next;
            load_due <= do_load;
        end
    end

    // R2
    fetch_to_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_EXEC));

    // R2
    exec_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_FETCH));

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> $stable(pc));

    // R8
    brz_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (do_brz && acc_zero) |=> (pc == $past(target)));

    // R8
    brz_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (do_brz && !acc_zero) |=> (pc == $past(pc) + PC_STEP));

endmodule

// File: rtl/acc_brz_cpu.sv
module acc_brz_cpu
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 12,
    localparam int ADDR_W = WORD_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata
);

    phase_e            phase;
    ctl_t              ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] addr_field;
    logic [OPC_W-1:0]  opc_bits;
    logic [WORD_W-1:0] acc_q;
    logic              acc_zero;
    logic              load_due;

    assign opc_bits   = mem_rdata[WORD_W-1 -: OPC_W];
    assign addr_field = mem_rdata[ADDR_W-1:0];

    acc_decode u_dec (
        .phase (phase),
        .opc   (opc_bits),
        .ctl   (ctl)
    );

    acc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .do_load  (ctl.rd_mem),
        .do_brz   (ctl.brz),
        .acc_zero (acc_zero),
        .target   (addr_field),
        .phase    (phase),
        .pc       (pc_q),
        .load_due (load_due)
    );

    acc_unit #(.WORD_W(WORD_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load_due (load_due),
        .do_clr   (ctl.acc_clr),
        .do_inc   (ctl.acc_inc),
        .rdata    (mem_rdata),
        .acc      (acc_q),
        .acc_zero (acc_zero)
    );

    always_comb begin
        if (ctl.rd_mem || ctl.wr_mem) begin
            mem_addr = addr_field;
        end else begin
            mem_addr = pc_q;
        end
    end

    assign mem_we    = ctl.wr_mem;
    assign mem_wdata = acc_q;

    // R5
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(acc_q));

    // R10
    rsv_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && opc_bits[2] && opc_bits[1:0] != 2'b00) |-> !mem_we);

    // R10
    rsv_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && opc_bits[2] && opc_bits[1:0] != 2'b00) |=> $stable(acc_q));

endmodule

// File: tb/sim_acc_brz_cpu.sv
`timescale 1ns/1ps
module sim_acc_brz_cpu;

    localparam int W     = 12;
    localparam int AW    = 9;
    localparam int DEPTH = 512;
    localparam int MAXI  = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic          mem_we;
    logic [W-1:0]  mem_rdata;

    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  img [DEPTH];
    logic [W-1:0]  rm  [DEPTH];
    logic          pl_en = 1'b0;

    logic [AW-1:0] exp_fa [MAXI];
    logic          exp_we [MAXI];
    logic [AW-1:0] exp_ea [MAXI];
    logic [W-1:0]  exp_wd [MAXI];

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    acc_brz_cpu u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (pl_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [W-1:0] enc(input int op, input int a);
        return {op[2:0], a[AW-1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic clear_img(input logic [W-1:0] fill);
        for (int i = 0; i < DEPTH; i++) img[i] = fill;
    endtask

    // instruction-level model of R3..R10
    task automatic model_run(input int n);
        logic [AW-1:0] pc;
        logic [W-1:0]  acc;
        logic [W-1:0]  w;
        logic [AW-1:0] a;
        for (int i = 0; i < DEPTH; i++) rm[i] = img[i];
        pc  = '0;
        acc = '0;
        for (int k = 0; k < n; k++) begin
            w = rm[pc];
            a = w[AW-1:0];
            exp_fa[k] = pc;
            exp_we[k] = 1'b0;
            exp_ea[k] = pc;
            exp_wd[k] = acc;
            case (w[W-1:AW])
                3'b000: begin acc = rm[a]; exp_ea[k] = a; pc = pc + 1'b1; end
                3'b001: begin rm[a] = acc; exp_we[k] = 1'b1; exp_ea[k] = a; pc = pc + 1'b1; end
                3'b010: begin acc = '0; pc = pc + 1'b1; end
                3'b011: begin acc = acc + 1'b1; pc = pc + 1'b1; end
                3'b100: begin if (acc == '0) pc = a; else pc = pc + 1'b1; end
                default: pc = pc + 1'b1;
            endcase
        end
    endtask

    task automatic run_prog(input string name, input int n);
        int bad;
        int bad_k;
        int bad_act;
        int bad_exp;
        model_run(n);
        @(negedge clk);
        rst   = 1'b1;
        pl_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check(mem_addr == '0 && mem_we == 1'b0, "R1", {name, " reset outputs"},
              int'({mem_we, mem_addr}), 0);
        pl_en = 1'b0;
        rst   = 1'b0;
        bad = 0; bad_k = 0; bad_act = 0; bad_exp = 0;
        for (int k = 0; k < n; k++) begin
            if (bad == 0 && (mem_addr !== exp_fa[k] || mem_we !== 1'b0)) begin
                bad = 1; bad_k = k; bad_act = int'(mem_addr); bad_exp = int'(exp_fa[k]);
            end
            @(negedge clk);
            if (bad == 0 && (mem_we !== exp_we[k] || mem_addr !== exp_ea[k] ||
                (exp_we[k] && mem_wdata !== exp_wd[k]))) begin
                bad = 2; bad_k = k;
                bad_act = int'({mem_we, mem_wdata, mem_addr});
                bad_exp = int'({exp_we[k], exp_wd[k], exp_ea[k]});
            end
            @(negedge clk);
        end
        // R2 R5 R8: cycle trace of fetch and execute phases
        check(bad == 0, "R2/R5/R8", $sformatf("%s trace step %0d phase %0d", name, bad_k, bad),
              bad_act, bad_exp);
        bad = 0; bad_k = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (bad == 0 && mem[i] !== rm[i]) begin
                bad = 1; bad_k = i; bad_act = int'(mem[i]); bad_exp = int'(rm[i]);
            end
        end
        // R4 R9: final memory image
        check(bad == 0, "R4/R9", $sformatf("%s memory word %0d", name, bad_k), bad_act, bad_exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        // R1
        check(mem_addr == '0 && mem_we == 1'b0, "R1", "initial reset outputs",
              int'({mem_we, mem_addr}), 0);

        // R7: wrap of increment
        clear_img('0);
        img[0] = enc(0, 100); img[1] = enc(3, 0); img[2] = enc(1, 101);
        img[3] = enc(3, 0);   img[4] = enc(1, 102);
        img[100] = 12'hFFF; img[101] = 12'h555; img[102] = 12'h555;
        run_prog("wrap", 5);
        check(mem[101] == 12'h000, "R7", "FFF plus one", int'(mem[101]), 0);
        check(mem[102] == 12'h001, "R7", "zero plus one", int'(mem[102]), 1);

        // R8: branch taken and not taken
        clear_img('0);
        img[0] = enc(2, 0); img[1] = enc(4, 10); img[2] = enc(1, 200);
        img[10] = enc(3, 0); img[11] = enc(4, 20); img[12] = enc(1, 201);
        img[200] = 12'h5A5; img[201] = 12'h5A5;
        run_prog("branch", 5);
        check(mem[200] == 12'h5A5, "R8", "skipped store left word", int'(mem[200]), 12'h5A5);
        check(mem[201] == 12'h001, "R8", "fall-through store", int'(mem[201]), 1);

        // R9: store rewrites the very next instruction
        clear_img('0);
        img[0] = enc(0, 50); img[1] = enc(1, 2); img[2] = enc(1, 60); img[3] = enc(1, 60);
        img[50] = enc(1, 61); img[60] = 12'h000; img[61] = 12'h000;
        run_prog("selfmod", 4);
        check(mem[61] == enc(1, 61), "R9", "rewritten instruction ran", int'(mem[61]), int'(enc(1, 61)));
        check(mem[2] == enc(1, 61), "R9", "code word overwritten", int'(mem[2]), int'(enc(1, 61)));

        // R10: reserved opcodes act as no-ops
        clear_img('0);
        img[0] = enc(0, 100); img[1] = enc(5, 101); img[2] = enc(6, 102);
        img[3] = enc(7, 101); img[4] = enc(1, 103);
        img[100] = 12'h123; img[101] = 12'h0AA; img[102] = 12'h0BB; img[103] = 12'h000;
        run_prog("reserved", 5);
        check(mem[103] == 12'h123, "R10", "acc unchanged by reserved codes", int'(mem[103]), 12'h123);
        check(mem[101] == 12'h0AA && mem[102] == 12'h0BB, "R10", "no write by reserved codes",
              int'(mem[101]), 12'h0AA);

        // R6: clear after load
        clear_img('0);
        img[0] = enc(0, 100); img[1] = enc(2, 0); img[2] = enc(1, 101);
        img[100] = 12'h777; img[101] = 12'hFFF;
        run_prog("clear", 3);
        check(mem[101] == 12'h000, "R6", "cleared acc stored", int'(mem[101]), 0);

        // R8 sequential wrap 511 -> 0, R1 acc zero out of reset
        clear_img('0);
        img[0] = enc(4, 511); img[511] = enc(3, 0); img[1] = enc(1, 300);
        img[300] = 12'hABC;
        run_prog("pcwrap", 4);
        check(mem[300] == 12'h001, "R8", "wrap from 511 then fall-through", int'(mem[300]), 1);

        // R4: load then store copies a word
        clear_img('0);
        img[0] = enc(0, 400); img[1] = enc(1, 401); img[400] = 12'h9C3; img[401] = 12'h000;
        run_prog("copy", 2);
        check(mem[401] == 12'h9C3, "R4", "loaded word stored", int'(mem[401]), 12'h9C3);

        // random self-modifying programs confined to a small code region (R3 R9)
        for (int p = 0; p < 12; p++) begin
            for (int i = 0; i < DEPTH; i++) img[i] = W'($urandom);
            for (int i = 0; i < 64; i++) img[i] = enc(int'($urandom % 8), int'($urandom % 64));
            run_prog($sformatf("rand%0d", p), 150);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule